// File: doc/BRIEF.md
# Binary-Weighted Time-Pulse Converter

This block turns a small binary word into a length of time. A start strobe captures the word. The block then runs through one timing window per bit, starting with the least significant bit. The window for bit b lasts 2^b clock periods, and each window is one half-rate step of a divide-by-two chain measured in reference clock periods. The single output line is high during a window only when the matching captured bit is 1. Over the whole run, the line is therefore high for exactly the captured value in clock periods. One clock period stands for the value one.

The output is meant to gate a constant current source into an integrating capacitor, so the charge delivered is proportional to the word. The current source and the capacitor are not part of this block. One idle cycle separates consecutive windows. As a result, every conversion takes the same number of cycles whatever the data is. A one-cycle completion flag marks the end of each conversion.

Top module: `time_pulse_dac`

## Requirements
- R1: While reset is asserted and after it is released, with no start, `pulse_o` and `done_o` are both 0.
- R2: A start seen high at a rising edge while idle is accepted. The window for bit 0 occupies the cycle after the accepting edge. Windows follow in order bit 0, bit 1, bit 2, bit 3 and are 1, 2, 4 and 8 cycles wide. Exactly one idle cycle separates consecutive windows, so with DATA_W=4 the window cycles are offsets 0, 2–3, 5–8 and 10–17 after the accepting edge.
- R3: During the window of bit b, `pulse_o` equals captured data bit b. `pulse_o` is 0 in every gap cycle and whenever no conversion runs.
- R4: The number of cycles with `pulse_o` high in one conversion equals the captured value, taken as an unsigned number.
- R5: `done_o` is high for exactly one cycle, at offset 2^DATA_W + DATA_W − 2 (18 for DATA_W=4) after the accepting edge.
- R6: A start strobe that arrives while a conversion runs is ignored: the running conversion keeps its timing and its data.
- R7: A captured value of zero leaves `pulse_o` low for the whole conversion, and `done_o` still pulses at the usual offset.
- R8: `data_i` is captured only at the accepting edge. Changes to it during a conversion do not affect the output.
- R9: A start held high during the `done_o` cycle is accepted at the next edge, so conversions can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one period is one unit of value |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| data_i | input | DATA_W | Word to convert, captured on an accepted start |
| pulse_o | output | 1 | Charge-enable output; high time equals the captured value |
| done_o | output | 1 | One-cycle flag at the end of a conversion |

## Verification
The hardest case to reach is a start that arrives at the boundary of a conversion. If it lands in the last window cycle, it must be ignored. If it lands in the completion cycle, it must be accepted. The stimulus therefore holds start high continuously across the final window and into the done cycle, while also changing the data lines, and then checks that the second conversion starts exactly one edge after the done cycle. Stray starts and data changes are also injected in the middle of windows and in the middle of gaps. A reference model that tracks the offset within each conversion checks the output on every cycle.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WIN  = 2'd1,
    PH_GAP  = 2'd2
  } tpd_phase_e;

endpackage

// File: rtl/tpd_window_counter.sv
module tpd_window_counter #(
  parameter int CNT_W = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;
  logic [CNT_W-1:0] weight;
  logic [CNT_W-1:0] limit;

  // Width of the current window in cycles: 2^idx
  assign weight = CNT_W'(1) << idx_i;
  assign limit  = weight - CNT_W'(1);

  always_comb begin
    cnt_ce = clr_i | en_i;
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == limit);

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q < limit)); // R2

endmodule

// File: rtl/tpd_sequencer.sv
module tpd_sequencer
  import tpd_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             win_last_i,
  output tpd_phase_e       phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tpd_phase_e       phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             state_ce;

  always_comb begin
    phase_d   = phase_q;
    idx_d     = idx_q;
    done_d    = 1'b0;
    load_o    = 1'b0;
    cnt_clr_o = 1'b0;
    cnt_en_o  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d   = PH_WIN;
          idx_d     = '0;
          load_o    = 1'b1;
          cnt_clr_o = 1'b1;
        end
      end
      PH_WIN: begin
        if (win_last_i) begin
          cnt_clr_o = 1'b1;
          if (idx_q == LAST_IDX) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end else begin
            phase_d = PH_GAP;
          end
        end else begin
          cnt_en_o = 1'b1;
        end
      end
      PH_GAP: begin
        phase_d = PH_WIN;
        idx_d   = idx_q + IDX_W'(1);
      end
      default: begin
        phase_d = PH_IDLE;
      end
    endcase
  end

  assign state_ce = (phase_d != phase_q) | (idx_d != idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else if (state_ce) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign done_o  = done_q;

  AST_GAP_THEN_NEXT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_GAP) |=> (phase_q == PH_WIN) && (idx_q == $past(idx_q) + IDX_W'(1))); // R2

  AST_WIN_HOLDS_UNTIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WIN) && !win_last_i |=> (phase_q == PH_WIN) && $stable(idx_q)); // R6

  AST_DONE_AFTER_LAST_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WIN) && win_last_i && (idx_q == LAST_IDX) |=> done_q && (phase_q == PH_IDLE)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5

endmodule

// File: rtl/tpd_gate.sv
module tpd_gate
  import tpd_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  tpd_phase_e        phase_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              pulse_o
);

  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] bit_hit;
  logic              in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load_i) begin
      data_q <= data_i;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bitsel
    assign bit_hit[b] = (idx_i == IDX_W'(b)) & data_q[b];
  end

  assign in_win  = (phase_i == PH_WIN);
  assign pulse_o = in_win & (|bit_hit);

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(data_q)); // R8

  AST_ONE_BIT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bit_hit)); // R3

endmodule

// File: rtl/time_pulse_dac.sv
module time_pulse_dac
  import tpd_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pulse_o,
  output logic              done_o
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CNT_W = DATA_W;

  tpd_phase_e       phase;
  logic [IDX_W-1:0] idx;
  logic             load;
  logic             cnt_clr;
  logic             cnt_en;
  logic             win_last;

  tpd_sequencer #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .win_last_i (win_last),
    .phase_o    (phase),
    .idx_o      (idx),
    .load_o     (load),
    .cnt_clr_o  (cnt_clr),
    .cnt_en_o   (cnt_en),
    .done_o     (done_o)
  );

  tpd_window_counter #(
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .idx_i  (idx),
    .last_o (win_last)
  );

  tpd_gate #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .data_i  (data_i),
    .phase_i (phase),
    .idx_i   (idx),
    .pulse_o (pulse_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !pulse_o); // R3

endmodule

// File: tb/time_pulse_dac_tb.sv
module time_pulse_dac_tb;

  localparam int DW    = 4;
  localparam int TOTAL = (1 << DW) + DW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          pulse_o;
  logic          done_o;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  time_pulse_dac #(.DATA_W(DW)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .data_i  (data_i),
    .pulse_o (pulse_o),
    .done_o  (done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bit_at(input int off);
    int pos = 0;
    for (int b = 0; b < DW; b++) begin
      if (off >= pos && off < pos + (1 << b)) return b;
      pos += (1 << b) + 1;
    end
    return -1;
  endfunction

  // Behavioural reference model: conversion offset tracking
  bit          m_busy = 0;
  bit          m_done = 0;
  int          m_off = 0;
  logic [DW-1:0] m_data = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_off = 0; m_data = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_off++;
        if (m_off == TOTAL) begin
          m_busy = 0;
          m_done = 1;
        end
      end else if (start_i) begin
        m_busy = 1;
        m_off  = 0;
        m_data = data_i;
      end
    end
  end

  function automatic bit exp_pulse();
    int b;
    if (!m_busy) return 1'b0;
    b = bit_at(m_off);
    if (b < 0) return 1'b0;
    return m_data[b];
  endfunction

  // Per-cycle comparison and per-conversion capture
  int        hi_cnt = 0;
  logic [31:0] mask = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(pulse_o == exp_pulse(), "R3 pulse vs model", pulse_o, exp_pulse());
      check(done_o == m_done, "R5 done vs model", done_o, m_done);
      if (m_busy && pulse_o) begin
        hi_cnt++;
        mask[m_off] = 1'b1;
      end
    end
  end

  function automatic logic [31:0] win_mask(input logic [DW-1:0] d);
    logic [31:0] m = '0;
    for (int o = 0; o < TOTAL; o++) begin
      if (bit_at(o) >= 0 && d[bit_at(o)]) m[o] = 1'b1;
    end
    return m;
  endfunction

  // Called at a negedge; start is accepted at the following posedge.
  // Returns at the negedge in the done cycle. Optional disturbance at offset dist_off.
  task automatic run_conv(input logic [DW-1:0] d, input int dist_off, input bit dist_start,
                          input bit hold_at_end, input string req);
    int k;
    hi_cnt = 0;
    mask   = '0;
    start_i = 1'b1;
    data_i  = d;
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    while (!done_o && k < 40) begin
      if (k == dist_off) begin
        start_i = dist_start;
        data_i  = ~d;
      end else if (k == dist_off + 1) begin
        start_i = 1'b0;
      end
      if (hold_at_end && k == TOTAL - 1) begin
        start_i = 1'b1;
        data_i  = ~d;
      end
      @(negedge clk);
      k++;
    end
    check(k == TOTAL, {req, " done latency"}, k, TOTAL);
    check(hi_cnt == int'(d), {req, " R4 high-cycle count"}, hi_cnt, int'(d));
    check(mask == win_mask(d), {req, " R2 window placement"}, int'(mask), int'(win_mask(d)));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    #3;
    check(pulse_o == 1'b0, "R1 pulse in reset", pulse_o, 0);
    check(done_o == 1'b0, "R1 done in reset", done_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pulse_o == 1'b0 && done_o == 1'b0, "R1 idle after reset", {pulse_o, done_o}, 0);

    // R2 / R3 / R4: full scale and distinct patterns
    run_conv(4'hF, -5, 1'b0, 1'b0, "R2 all ones");
    @(negedge clk);
    run_conv(4'b0101, -5, 1'b0, 1'b0, "R3 pattern 0101");
    @(negedge clk);
    run_conv(4'b1010, -5, 1'b0, 1'b0, "R3 pattern 1010");
    @(negedge clk);
    run_conv(4'b1000, -5, 1'b0, 1'b0, "R4 msb only");
    @(negedge clk);
    run_conv(4'b0001, -5, 1'b0, 1'b0, "R4 lsb only");
    @(negedge clk);

    // R7: zero input
    run_conv(4'h0, -5, 1'b0, 1'b0, "R7 zero");
    @(negedge clk);

    // R6: stray start mid-window and mid-gap (data also flips)
    run_conv(4'b0110, 6, 1'b1, 1'b0, "R6 start in window");
    @(negedge clk);
    run_conv(4'b1011, 4, 1'b1, 1'b0, "R6 start in gap");
    @(negedge clk);

    // R8: data lines change mid-conversion without start
    run_conv(4'b1101, 2, 1'b0, 1'b0, "R8 data change");
    @(negedge clk);

    // R9: start held across last window into done cycle; accepted back to back
    run_conv(4'b0011, -5, 1'b0, 1'b1, "R9 first");
    check(start_i == 1'b1, "R9 start held into done", start_i, 1);
    run_conv(4'b1100, -5, 1'b0, 1'b0, "R9 back to back");
    @(negedge clk);

    // Every value once
    for (int v = 0; v < (1 << DW); v++) begin
      run_conv(DW'(v), -5, 1'b0, 1'b0, "R4 sweep");
      @(negedge clk);
    end

    repeat (3) @(negedge clk);
    check(pulse_o == 1'b0 && done_o == 1'b0, "R1 quiet at end", {pulse_o, done_o}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule